// File: doc/BRIEF.md
# Power-Fail Shutdown and Reset Sequencer

This block orders the two control lines that a processor board needs when its supply goes away or comes back. One line is an active-low save warning that tells firmware to store volatile state. The other is an active-low processor reset. Two inputs drive the sequence. The first is an active-low power-down request, for example a mains-loss signal. The second is an active-high under-voltage flag from an outside comparator that watches the main output rail. The warning is always issued before the reset, and a warning is always followed by a reset.

The two power-down delays are run-time tick counts on input ports. The warning delay sets how long the request must persist before the warning falls. The reset delay sets the gap between the warning and the reset. The two release delays are fixed parameters, one for the warning and one for the reset. An under-voltage flag overrides every phase and pulls both outputs low. Both inputs pass through two-stage synchronizers.

In the requirements, "edge k" counts rising clock edges. Edge 0 is the first rising edge that samples a changed input pin.

Top module: `pfail_sequencer`

## Requirements
- R1: While `rst` is high, both outputs are low. After `rst` falls, with `pd_req_n` high and `uv_flag` low, `save_n` rises at edge RELEASE_SAVE_TICKS+3, where edge 0 is the first edge with `rst` low. `cpu_rst_n` rises RELEASE_RST_TICKS+1 edges after `save_n` rises.
- R2: From the idle state (both outputs high), when `pd_req_n` falls, `save_n` falls at edge `save_dly`+3. `cpu_rst_n` stays high until then. This holds over the full range of `save_dly`, up to its all-ones value.
- R3: `cpu_rst_n` falls `rst_dly`+1 edges after `save_n` falls.
- R4: A low pulse on `pd_req_n` that lasts at most `save_dly`+1 edges leaves both outputs high. A pulse of `save_dly`+2 edges or more produces the warning.
- R5: Once `save_n` has fallen, `cpu_rst_n` still falls `rst_dly`+1 edges later, even if `pd_req_n` returns high in that interval.
- R6: When `uv_flag` rises, both outputs are low at edge 2, in any phase.
- R7: After both outputs are low, `save_n` rises at edge RELEASE_SAVE_TICKS+3. Edge 0 here is the first edge that samples the last of these two conditions: `pd_req_n` high and `uv_flag` low. `cpu_rst_n` rises RELEASE_RST_TICKS+1 edges after `save_n`. Both outputs stay low for as long as `uv_flag` is high.
- R8: `cpu_rst_n` never rises while `save_n` is low. `cpu_rst_n` never falls while `save_n` is high.
- R9: If `pd_req_n` falls while the reset release is being timed (`save_n` high, `cpu_rst_n` low), `save_n` falls at edge `save_dly`+3. `cpu_rst_n` stays low throughout.
- R10: If `pd_req_n` returns high before that warning falls, the reset release restarts. `cpu_rst_n` then rises at edge RELEASE_RST_TICKS+3, and `save_n` stays high.
- R11: If `pd_req_n` falls while the warning release is being timed, the release is abandoned and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_req_n | input | 1 | Power-down request, active low, asynchronous |
| uv_flag | input | 1 | Under-voltage flag of the main rail, active high, asynchronous |
| save_dly | input | DLY_W | Warning delay in ticks, sampled when timing starts |
| rst_dly | input | DLY_W | Warning-to-reset delay in ticks, sampled when timing starts |
| save_n | output | 1 | Save warning, active low, registered |
| cpu_rst_n | output | 1 | Processor reset, active low, registered |

## Verification
A wrong phase state or counter value appears at the ports as an output edge at the wrong time: one tick early or late when a delay count is off, or no edge at all when the state goes the wrong way. Every such fault shows up no later than the longest configured delay plus three edges after the input change. The bench sweeps small delay values exhaustively and counts edges to each transition. A wrong state can also release the reset before the warning or drop the reset with no warning. That ordering fault is visible on the very cycle the bad edge occurs.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_ON = 3'd0,
        ST_WAIT_T1 = 3'd1,
        ST_WAIT_T2 = 3'd2,
        ST_ALL_LOW = 3'd3,
        ST_WAIT_T3 = 3'd4,
        ST_WAIT_T4 = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic save_n;
        logic rst_n;
    } seq_out_t;

    localparam seq_out_t OUT_ALL_LOW = '{save_n: 1'b0, rst_n: 1'b0};

    // Output levels for the state being entered; reset holds its level
    // in the two power-down timing states so a restarted request keeps it.
    function automatic seq_out_t decode_out(input seq_state_e nxt, input seq_out_t cur);
        seq_out_t o;
        o = cur;
        unique case (nxt)
            ST_IDLE_ON: begin o.save_n = 1'b1; o.rst_n = 1'b1; end
            ST_WAIT_T1: begin o.save_n = 1'b1; end
            ST_WAIT_T2: begin o.save_n = 1'b0; end
            ST_ALL_LOW: begin o.save_n = 1'b0; o.rst_n = 1'b0; end
            ST_WAIT_T3: begin o.save_n = 1'b0; o.rst_n = 1'b0; end
            ST_WAIT_T4: begin o.save_n = 1'b1; o.rst_n = 1'b0; end
            default:    begin o = OUT_ALL_LOW; end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign q = stage2;

    // R6: every output bit follows the input after exactly two stages
    assert_two_stage_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pfs_timer.sv
module pfs_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);

    // R3: the sequencer never asks for a decrement of an expired count
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        dec |-> (count != '0));

    // R2: with no request the count keeps its value
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(count));

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
#(
    parameter int unsigned DLY_W = 8,
    parameter int unsigned T3    = 4,
    parameter int unsigned T4    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n_s,
    input  logic             uv_s,
    input  logic [DLY_W-1:0] t1_ticks,
    input  logic [DLY_W-1:0] t2_ticks,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    output logic             tmr_dec,
    output seq_out_t         outs
);
    localparam logic [DLY_W-1:0] T3_TICKS = DLY_W'(T3);
    localparam logic [DLY_W-1:0] T4_TICKS = DLY_W'(T4);

    seq_state_e state;
    seq_state_e nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (state)
            ST_IDLE_ON: begin
                if (uv_s) begin
                    nxt = ST_ALL_LOW;
                end else if (!pd_n_s) begin
                    nxt      = ST_WAIT_T1;
                    tmr_load = 1'b1;
                    tmr_val  = t1_ticks;
                end
            end
            ST_WAIT_T1: begin
                if (uv_s) begin
                    nxt = ST_ALL_LOW;
                end else if (pd_n_s) begin
                    if (outs.rst_n) begin
                        nxt = ST_IDLE_ON;
                    end else begin
                        nxt      = ST_WAIT_T4;
                        tmr_load = 1'b1;
                        tmr_val  = T4_TICKS;
                    end
                end else if (tmr_zero) begin
                    nxt      = ST_WAIT_T2;
                    tmr_load = 1'b1;
                    tmr_val  = t2_ticks;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WAIT_T2: begin
                if (uv_s || tmr_zero) begin
                    nxt = ST_ALL_LOW;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ALL_LOW: begin
                if (pd_n_s && !uv_s) begin
                    nxt      = ST_WAIT_T3;
                    tmr_load = 1'b1;
                    tmr_val  = T3_TICKS;
                end
            end
            ST_WAIT_T3: begin
                if (uv_s || !pd_n_s) begin
                    nxt = ST_ALL_LOW;
                end else if (tmr_zero) begin
                    nxt      = ST_WAIT_T4;
                    tmr_load = 1'b1;
                    tmr_val  = T4_TICKS;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WAIT_T4: begin
                if (uv_s) begin
                    nxt = ST_ALL_LOW;
                end else if (!pd_n_s) begin
                    nxt      = ST_WAIT_T1;
                    tmr_load = 1'b1;
                    tmr_val  = t1_ticks;
                end else if (tmr_zero) begin
                    nxt = ST_IDLE_ON;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: begin
                nxt = ST_ALL_LOW;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ALL_LOW;
            outs  <= OUT_ALL_LOW;
        end else begin
            state <= nxt;
            outs  <= decode_out(nxt, outs);
        end
    end

    // R5: the reset phase runs to its end unless the rail collapses
    assert_t2_completes_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_T2 && !uv_s) |=> (state == ST_WAIT_T2 || state == ST_ALL_LOW));

    // R11: a dropped request during warning release returns to all-low
    assert_t3_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_T3 && !pd_n_s) |=> (state == ST_ALL_LOW));

    // R7: release never begins while the rail is low
    assert_release_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ALL_LOW && uv_s) |=> (state == ST_ALL_LOW));

endmodule

// File: rtl/pfail_sequencer.sv
module pfail_sequencer
    import pfs_pkg::*;
#(
    parameter int unsigned DLY_W               = 25,
    parameter int unsigned RELEASE_SAVE_TICKS  = 3_125_000,
    parameter int unsigned RELEASE_RST_TICKS   = 25_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req_n,
    input  logic             uv_flag,
    input  logic [DLY_W-1:0] save_dly,
    input  logic [DLY_W-1:0] rst_dly,
    output logic             save_n,
    output logic             cpu_rst_n
);
    localparam int unsigned SYNC_W = 2;
    // bit 0: power-down request (reset value: asserted), bit 1: under-voltage (asserted)
    localparam logic [SYNC_W-1:0] SYNC_RST = 2'b10;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_in;
    logic              pd_n_s;
    logic              uv_s;
    logic              tmr_load;
    logic [DLY_W-1:0]  tmr_val;
    logic              tmr_dec;
    logic              tmr_zero;
    seq_out_t          outs;

    assign raw_in = {uv_flag, pd_req_n};

    pfs_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    assign pd_n_s = sync_in[0];
    assign uv_s   = sync_in[1];

    pfs_timer #(.W(DLY_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pfs_fsm #(
        .DLY_W (DLY_W),
        .T3    (RELEASE_SAVE_TICKS),
        .T4    (RELEASE_RST_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pd_n_s   (pd_n_s),
        .uv_s     (uv_s),
        .t1_ticks (save_dly),
        .t2_ticks (rst_dly),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .outs     (outs)
    );

    assign save_n    = outs.save_n;
    assign cpu_rst_n = outs.rst_n;

    // R6: a synchronized under-voltage flag forces both lines low next edge
    assert_uv_override_R6: assert property (@(posedge clk) disable iff (rst)
        uv_s |=> (!save_n && !cpu_rst_n));

    // R8: reset is released only with the warning already released
    assert_rst_rise_order_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_n) |-> save_n);

    // R8: reset is applied only with the warning already applied
    assert_rst_fall_order_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst_n) |-> !save_n);

    // R2: the warning falls only on a live request or an under-voltage
    assert_save_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(save_n) |-> ($past(uv_s) || !$past(pd_n_s)));

    // R7: the warning is released only with the rail good
    assert_save_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(save_n) |-> !$past(uv_s));

endmodule

// File: tb/test_pfail_sequencer.sv
module test_pfail_sequencer;

    localparam int unsigned DW = 8;
    localparam int T3 = 6;
    localparam int T4 = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pd_req_n = 1'b1;
    logic          uv_flag = 1'b0;
    logic [DW-1:0] save_dly = '0;
    logic [DW-1:0] rst_dly = '0;
    logic          save_n;
    logic          cpu_rst_n;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfail_sequencer #(
        .DLY_W              (DW),
        .RELEASE_SAVE_TICKS (T3),
        .RELEASE_RST_TICKS  (T4)
    ) i_pfail_sequencer (
        .clk       (clk),
        .rst       (rst),
        .pd_req_n  (pd_req_n),
        .uv_flag   (uv_flag),
        .save_dly  (save_dly),
        .rst_dly   (rst_dly),
        .save_n    (save_n),
        .cpu_rst_n (cpu_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts falling edges until the chosen output (0: save_n, 1: cpu_rst_n)
    // reaches lvl; flags whether the other output moved first.
    task automatic measure(input int which, input bit lvl, input int lim,
                           output int n, output bit moved);
        bit o0;
        o0 = (which == 0) ? cpu_rst_n : save_n;
        n = 0;
        moved = 1'b0;
        while (n <= lim) begin
            @(negedge clk);
            n++;
            if (((which == 0) ? save_n : cpu_rst_n) == lvl) break;
            if (((which == 0) ? cpu_rst_n : save_n) != o0) moved = 1'b1;
        end
    endtask

    // Release from all-low; the enabling input was driven at this negedge.
    task automatic go_up(input string req);
        int n;
        bit m;
        measure(0, 1'b1, 100, n, m);
        chk(n == T3 + 4, {req, " save release"}, n, T3 + 4);
        chk(!m, "R8 reset before warning", int'(m), 0);
        measure(1, 1'b1, 100, n, m);
        chk(n == T4 + 1, {req, " reset release"}, n, T4 + 1);
    endtask

    task automatic uv_pulse();
        @(negedge clk) uv_flag = 1'b1;
        repeat (5) @(negedge clk);
        uv_flag = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int n;
        bit m;
        bit fell;
        int fall_at;

        // R1: reset state and start-up release
        repeat (3) @(negedge clk);
        chk(save_n == 1'b0, "R1 save in reset", save_n, 0);
        chk(cpu_rst_n == 1'b0, "R1 reset in reset", cpu_rst_n, 0);
        rst = 1'b0;
        go_up("R1");

        // R2/R3/R7: sweep of adjustable delays
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                @(negedge clk);
                save_dly = DW'(a);
                rst_dly  = DW'(b);
                pd_req_n = 1'b0;
                measure(0, 1'b0, 300, n, m);
                chk(n == a + 4, "R2 warning delay", n, a + 4);
                chk(!m, "R2 reset early", int'(m), 0);
                measure(1, 1'b0, 300, n, m);
                chk(n == b + 1, "R3 reset delay", n, b + 1);
                pd_req_n = 1'b1;
                go_up("R7");
            end
        end

        // R2 boundary: all-ones warning delay
        @(negedge clk);
        save_dly = '1;
        rst_dly  = 8'd1;
        pd_req_n = 1'b0;
        measure(0, 1'b0, 300, n, m);
        chk(n == 255 + 4, "R2 max warning delay", n, 259);
        chk(!m, "R2 reset early at max", int'(m), 0);
        measure(1, 1'b0, 300, n, m);
        pd_req_n = 1'b1;
        go_up("R7");

        // R4: short request pulses
        save_dly = 8'd6;
        rst_dly  = 8'd2;
        for (int w = 1; w <= 10; w++) begin
            @(negedge clk) pd_req_n = 1'b0;
            fell = 1'b0;
            fall_at = 0;
            for (int k = 1; k <= 60; k++) begin
                if (k == w + 1) pd_req_n = 1'b1;
                @(negedge clk);
                if (!save_n && !fell) begin
                    fell = 1'b1;
                    fall_at = k;
                end
            end
            chk(fell == (w >= 8), "R4 pulse filter", int'(fell), int'(w >= 8));
            if (fell) chk(fall_at == 10, "R4 warning time", fall_at, 10);
            chk(save_n && cpu_rst_n, "R4 back to idle", {save_n, cpu_rst_n}, 3);
        end

        // R5: reset follows even if request withdrawn
        @(negedge clk);
        save_dly = 8'd2;
        rst_dly  = 8'd5;
        pd_req_n = 1'b0;
        measure(0, 1'b0, 100, n, m);
        pd_req_n = 1'b1;
        measure(1, 1'b0, 100, n, m);
        chk(n == 6, "R5 reset after withdraw", n, 6);
        measure(0, 1'b1, 100, n, m);
        chk(n <= 100, "R5 warning released", n, T3 + 2);
        measure(1, 1'b1, 100, n, m);
        chk(n == T4 + 1, "R7 reset release after R5", n, T4 + 1);

        // R6: under-voltage from idle
        @(negedge clk) uv_flag = 1'b1;
        measure(0, 1'b0, 100, n, m);
        chk(n == 3, "R6 uv from idle", n, 3);
        chk(cpu_rst_n == 1'b0, "R6 reset with uv", cpu_rst_n, 0);
        uv_flag = 1'b0;
        go_up("R7 uv");

        // R6: under-voltage during warning delay, R7 gate
        @(negedge clk);
        save_dly = 8'd20;
        pd_req_n = 1'b0;
        repeat (5) @(negedge clk);
        uv_flag = 1'b1;
        measure(0, 1'b0, 100, n, m);
        chk(n == 3, "R6 uv in t1", n, 3);
        chk(cpu_rst_n == 1'b0, "R6 reset in t1", cpu_rst_n, 0);
        pd_req_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!save_n && !cpu_rst_n, "R7 held by uv", {save_n, cpu_rst_n}, 0);
        uv_flag = 1'b0;
        go_up("R7 after uv");

        // R6: under-voltage during reset release
        uv_pulse();
        measure(0, 1'b1, 100, n, m);
        chk(n == T3 + 4, "R7 release after uv", n, T3 + 4);
        repeat (2) @(negedge clk);
        uv_flag = 1'b1;
        measure(0, 1'b0, 100, n, m);
        chk(n == 3, "R6 uv in t4", n, 3);
        chk(!m, "R6 reset stays low", int'(m), 0);
        uv_flag = 1'b0;
        go_up("R7");

        // R9: request during reset release
        uv_pulse();
        measure(0, 1'b1, 100, n, m);
        save_dly = 8'd3;
        rst_dly  = 8'd2;
        pd_req_n = 1'b0;
        measure(0, 1'b0, 100, n, m);
        chk(n == 3 + 4, "R9 warning in t4", n, 7);
        chk(!m && !cpu_rst_n, "R9 reset held", {m, cpu_rst_n}, 0);
        repeat (10) @(negedge clk);
        chk(!cpu_rst_n, "R9 reset still low", cpu_rst_n, 0);
        pd_req_n = 1'b1;
        go_up("R7 after R9");

        // R10: request withdrawn before its warning
        uv_pulse();
        measure(0, 1'b1, 100, n, m);
        save_dly = 8'd10;
        pd_req_n = 1'b0;
        repeat (3) @(negedge clk);
        pd_req_n = 1'b1;
        measure(1, 1'b1, 100, n, m);
        chk(n == T4 + 4, "R10 reset release restart", n, T4 + 4);
        chk(!m, "R10 warning stays high", int'(m), 0);

        // R11: request during warning release
        uv_pulse();
        repeat (4) @(negedge clk);
        pd_req_n = 1'b0;
        fell = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (save_n || cpu_rst_n) fell = 1'b1;
        end
        chk(!fell, "R11 release abandoned", int'(fell), 0);
        pd_req_n = 1'b1;
        go_up("R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule